// File: doc/BRIEF.md
# Asynchronous Static Memory Byte-Lane Controller

This block connects a synchronous host to an external asynchronous 16-bit static memory. The memory side has an active-low chip select, write strobe, output enable and one active-low enable per byte lane. The controller places these strobes in order and drives the shared data bus through a separate output-enable signal. Every memory timing limit is kept by counting clock cycles. The number of cycles for each limit is worked out at elaboration from nanosecond parameters and the clock period, always rounding up.

The host side is a valid/ready request channel. It carries a write flag, an address, write data and a per-lane mask. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The host must hold the request fields steady while `req_valid` is high and `req_ready` is low. It may drop or change the request freely once it has been taken. `req_ready` is high only when the controller is idle and is not in a completion cycle, so at most one access is ever outstanding. Completion comes back as a one-cycle `rsp_valid` pulse, with read data on `rsp_rdata`. That pulse has no back-pressure; the host must accept it.

A write ends on the rising edge of the write strobe. A read captures data only after the longest of the address-access, output-enable-access and read-cycle times has passed. After every read, the controller spends a recovery window with output enable high before it can accept the next request. This gives the memory time to release the data bus before the controller drives it.

Top module: `sram_async_ctl`

## Requirements
- R1: During and after reset, with no request taken: chip select, write strobe, output enable and every lane enable are high (inactive), `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only in the idle state, and is low in any cycle where `rsp_valid` is high. A request held valid while the controller is busy is taken exactly once, when `req_ready` next goes high.
- R3: A write with a non-zero mask runs as follows. Chip select goes low for one cycle with the write strobe high. The write strobe is then low for PULSE cycles. Then comes one cycle with the strobe high and chip select still low. Chip select then returns high. `mem_addr` stays stable the whole time chip select is low.
- R4: Lane enable bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A lane enable is low during an access exactly when the matching mask bit was 1 in the taken request.
- R5: `mem_dq_oe` is high only while the write strobe is low and during the cycle that follows. It is never high while output enable is low. While it is high, `mem_dq_o` equals the taken write data.
- R6: A read with a non-zero mask holds chip select and output enable low, with the write strobe high, for READ cycles. `rsp_valid` is high in the cycle after that window. `rsp_rdata` then carries the memory lanes that were enabled, and zero in each lane whose mask bit was 0.
- R7: After a read, chip select and output enable stay high for TURN cycles (at least one) before `req_ready` returns high.
- R8: `rsp_valid` is a single-cycle pulse. For a write it is high in the cycle in which the write strobe has just risen.
- R9: A request with mask 2'b00 touches no memory strobe. It produces `rsp_valid` in the next cycle, with `rsp_rdata` equal to zero.
- R10: Cycle counts are computed by rounding up from the clock period. PULSE is the largest of the write-pulse width, the data-setup time, and the write cycle time minus two cycles. READ is the largest of the address-access, output-enable-access and read-cycle times. TURN is the bus-release time, with a minimum of one cycle. At a 20 ns clock with the default ns values, PULSE=2, READ=3 and TURN=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 8*LANES | Write data |
| req_mask | input | LANES | Per-lane select, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*LANES | Read data, zero in lanes not selected |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | LANES | Lane enables, active low, bit 0 = bits 7:0 |
| mem_dq_o | output | 8*LANES | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 8*LANES | Data returned by memory |

## Verification
Call the edge that takes a request edge 0. After it, chip select goes low in the next cycle. For a write, the strobe falls one cycle later and stays low for PULSE cycles. The completion pulse then appears 2+PULSE cycles after edge 0. For a read, the completion pulse with its data arrives READ+1 cycles after edge 0. After that pulse, `req_ready` stays low for TURN cycles. A mask-zero request completes one cycle after edge 0. The bench keeps a behavioural reference model that counts these windows from edge 0. On every falling edge it compares every output against the model, so a strobe, pulse or data word that arrives one cycle early or late is a miscompare.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } ctl_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_async_fsm.sv
module sram_async_fsm
  import sram_async_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 4,
  parameter int unsigned READ_CYC  = 6,
  parameter int unsigned TURN_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  output ctl_state_e state,
  output logic       capture,
  output logic       wr_end
);

  localparam int unsigned MAXC = max3(PULSE_CYC, READ_CYC, TURN_CYC);
  localparam int unsigned CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  ctl_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (start_write) begin
              st_q <= ST_WSETUP;
            end else begin
              st_q  <= ST_RACC;
              cnt_q <= CW'(READ_CYC - 1);
            end
          end
        end
        ST_WSETUP: begin
          st_q  <= ST_WPULSE;
          cnt_q <= CW'(PULSE_CYC - 1);
        end
        ST_WPULSE: begin
          if (cnt_zero) st_q <= ST_WHOLD;
          else          cnt_q <= cnt_q - 1'b1;
        end
        ST_WHOLD: st_q <= ST_IDLE;
        ST_RACC: begin
          if (cnt_zero) begin
            st_q  <= ST_RTURN;
            cnt_q <= CW'(TURN_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RTURN: begin
          if (cnt_zero) st_q <= ST_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state   = st_q;
  assign capture = (st_q == ST_RACC) && cnt_zero;
  assign wr_end  = (st_q == ST_WPULSE) && cnt_zero;

endmodule

// File: rtl/sram_async_lane.sv
module sram_async_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       sel_in,
  input  logic [7:0] wbyte_in,
  input  logic       capture,
  input  logic       clear,
  input  logic       win,
  input  logic [7:0] rbyte_in,
  output logic       be_n,
  output logic [7:0] wbyte,
  output logic [7:0] rbyte
);

  logic       sel_q;
  logic [7:0] wbyte_q;
  logic [7:0] rbyte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wbyte_q <= '0;
      rbyte_q <= '0;
    end else begin
      if (load) begin
        sel_q   <= sel_in;
        wbyte_q <= wbyte_in;
      end
      if (clear)        rbyte_q <= '0;
      else if (capture) rbyte_q <= sel_q ? rbyte_in : 8'h00;
    end
  end

  assign be_n  = !(win && sel_q);
  assign wbyte = wbyte_q;
  assign rbyte = rbyte_q;

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_async_pkg::*;
#(
  parameter int unsigned AW          = 19,
  parameter int unsigned LANES       = 2,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned T_WP_NS     = 35,
  parameter int unsigned T_DW_NS     = 25,
  parameter int unsigned T_WC_NS     = 55,
  parameter int unsigned T_RC_NS     = 55,
  parameter int unsigned T_AA_NS     = 55,
  parameter int unsigned T_OE_NS     = 25,
  parameter int unsigned T_BUSOFF_NS = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [8*LANES-1:0] req_wdata,
  input  logic [LANES-1:0]   req_mask,
  output logic               rsp_valid,
  output logic [8*LANES-1:0] rsp_rdata,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_cs_n,
  output logic               mem_we_n,
  output logic               mem_oe_n,
  output logic [LANES-1:0]   mem_be_n,
  output logic [8*LANES-1:0] mem_dq_o,
  output logic               mem_dq_oe,
  input  logic [8*LANES-1:0] mem_dq_i
);

  localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = max3(ns_to_cyc(T_WP_NS, CLK_NS),
                                           ns_to_cyc(T_DW_NS, CLK_NS),
                                           (WC_CYC > 3) ? WC_CYC - 2 : 1);
  localparam int unsigned READ_CYC  = max3(ns_to_cyc(T_AA_NS, CLK_NS),
                                           ns_to_cyc(T_OE_NS, CLK_NS),
                                           ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int unsigned TURN_RAW  = ns_to_cyc(T_BUSOFF_NS, CLK_NS);
  localparam int unsigned TURN_CYC  = (TURN_RAW < 1) ? 1 : TURN_RAW;

  ctl_state_e    state;
  logic          capture;
  logic          wr_end;
  logic          accept;
  logic          is_nop;
  logic          done_q;
  logic          win;
  logic [AW-1:0] addr_q;

  assign is_nop    = (req_mask == '0);
  assign req_ready = (state == ST_IDLE) && !done_q;
  assign accept    = req_valid && req_ready;

  sram_async_fsm #(
    .PULSE_CYC(PULSE_CYC),
    .READ_CYC (READ_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept && !is_nop),
    .start_write(req_write),
    .state      (state),
    .capture    (capture),
    .wr_end     (wr_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) addr_q <= req_addr;
      done_q <= capture || wr_end || (accept && is_nop);
    end
  end

  assign win = (state == ST_WSETUP) || (state == ST_WPULSE) ||
               (state == ST_WHOLD)  || (state == ST_RACC);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_async_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .sel_in  (req_mask[i]),
      .wbyte_in(req_wdata[8*i +: 8]),
      .capture (capture),
      .clear   (accept && is_nop),
      .win     (win),
      .rbyte_in(mem_dq_i[8*i +: 8]),
      .be_n    (mem_be_n[i]),
      .wbyte   (mem_dq_o[8*i +: 8]),
      .rbyte   (rsp_rdata[8*i +: 8])
    );
  end

  assign mem_addr  = addr_q;
  assign mem_cs_n  = !win;
  assign mem_we_n  = (state != ST_WPULSE);
  assign mem_oe_n  = (state != ST_RACC);
  assign mem_dq_oe = (state == ST_WPULSE) || (state == ST_WHOLD);
  assign rsp_valid = done_q;

endmodule

// File: rtl/sram_async_chk.sv
module sram_async_chk #(
  parameter int unsigned AW    = 19,
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic             rsp_valid,
  input logic [AW-1:0]    mem_addr,
  input logic             mem_cs_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_be_n,
  input logic             mem_dq_oe
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

  // R2
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3
  we_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_cs_n));

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && (req_mask == '0)) |-> (mem_cs_n && (&mem_be_n)));

endmodule

bind sram_async_ctl sram_async_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_mask (req_mask),
  .rsp_valid(rsp_valid),
  .mem_addr (mem_addr),
  .mem_cs_n (mem_cs_n),
  .mem_we_n (mem_we_n),
  .mem_oe_n (mem_oe_n),
  .mem_be_n (mem_be_n),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctl_test.sv
module sram_async_ctl_test;

  localparam int AW  = 19;
  localparam int PER = 20;
  // R10: expected counts from ns values at a 20 ns clock, rounded up
  localparam int PULSE = 2;
  localparam int READ  = 3;
  localparam int TURN  = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int vectors = 0;
  int miscompares = 0;

  always #(PER/2) clk = ~clk;

  sram_async_ctl #(.AW(AW), .CLK_NS(PER)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // behavioural external memory (16 words)
  logic [15:0] arr [16];
  initial for (int i = 0; i < 16; i++) arr[i] = 16'hA5C3 ^ (16'(i) * 16'h0101);

  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) begin
      if (mem_be_n[0] === 1'b0) arr[mem_addr[3:0]][7:0]  = mem_dq_o[7:0];
      if (mem_be_n[1] === 1'b0) arr[mem_addr[3:0]][15:8] = mem_dq_o[15:8];
    end
  end

  always_comb begin
    if (mem_cs_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1) begin
      mem_dq_i[7:0]  = (mem_be_n[0] === 1'b0) ? arr[mem_addr[3:0]][7:0]  : 8'hEE;
      mem_dq_i[15:8] = (mem_be_n[1] === 1'b0) ? arr[mem_addr[3:0]][15:8] : 8'hEE;
    end else begin
      mem_dq_i = 16'hBAD0;
    end
  end

  // reference model: phase 0 idle, 1 setup, 2 strobe, 3 release, 4 read window, 5 recovery
  int          m_ph;
  int          m_left;
  bit          m_done;
  bit          m_take;
  bit          m_nd;
  logic [15:0] m_rd;
  logic [AW-1:0] m_a;
  logic [15:0] m_wd;
  logic [1:0]  m_mk;
  logic [15:0] shadow [16];
  initial for (int i = 0; i < 16; i++) shadow[i] = 16'hA5C3 ^ (16'(i) * 16'h0101);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_done = 0; m_rd = '0; m_mk = '0; m_a = '0; m_wd = '0;
    end else begin
      m_take = req_valid && (m_ph == 0) && !m_done;
      m_nd = 0;
      case (m_ph)
        0: if (m_take) begin
             m_a = req_addr; m_wd = req_wdata; m_mk = req_mask;
             if (req_mask == 2'b00) begin m_nd = 1; m_rd = '0; end
             else if (req_write) m_ph = 1;
             else begin m_ph = 4; m_left = READ; end
           end
        1: begin m_ph = 2; m_left = PULSE; end
        2: begin
             m_left--;
             if (m_left == 0) begin
               m_ph = 3; m_nd = 1;
               if (m_mk[0]) shadow[m_a[3:0]][7:0]  = m_wd[7:0];
               if (m_mk[1]) shadow[m_a[3:0]][15:8] = m_wd[15:8];
             end
           end
        3: m_ph = 0;
        4: begin
             m_left--;
             if (m_left == 0) begin
               m_ph = 5; m_nd = 1; m_left = TURN;
               m_rd[7:0]  = m_mk[0] ? shadow[m_a[3:0]][7:0]  : 8'h00;
               m_rd[15:8] = m_mk[1] ? shadow[m_a[3:0]][15:8] : 8'h00;
             end
           end
        5: begin m_left--; if (m_left == 0) m_ph = 0; end
        default: m_ph = 0;
      endcase
      m_done = m_nd;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_win;
      e_win = (m_ph >= 1 && m_ph <= 4);
      check("R3 R6 R10", "mem_cs_n", 32'(mem_cs_n), 32'(!e_win));
      check("R3 R10", "mem_we_n", 32'(mem_we_n), 32'(m_ph != 2));
      check("R6 R10", "mem_oe_n", 32'(mem_oe_n), 32'(m_ph != 4));
      check("R5", "mem_dq_oe", 32'(mem_dq_oe), 32'(m_ph == 2 || m_ph == 3));
      check("R4 R9", "mem_be_n", 32'(mem_be_n),
            32'({!(e_win && m_mk[1]), !(e_win && m_mk[0])}));
      check("R2 R7", "req_ready", 32'(req_ready), 32'(m_ph == 0 && !m_done));
      check("R8", "rsp_valid", 32'(rsp_valid), 32'(m_done));
      if (m_done) check("R6 R9", "rsp_rdata", 32'(rsp_rdata), 32'(m_rd));
      if (e_win) check("R3", "mem_addr", 32'(mem_addr), 32'(m_a));
      if (m_ph == 2 || m_ph == 3) check("R5", "mem_dq_o", 32'(mem_dq_o), 32'(m_wd));
    end
  end

  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "cs/we/oe", 32'({mem_cs_n, mem_we_n, mem_oe_n}), 32'h7);
    check("R1", "be_n", 32'(mem_be_n), 32'h3);
    check("R1", "dq_oe", 32'(mem_dq_oe), 32'h0);
    check("R1", "ready/valid", 32'({req_ready, rsp_valid}), 32'h2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", 32'({req_ready, mem_cs_n}), 32'h3);

    // R3 R6: full word write and readback, upper address bits set
    issue(1, 19'h7FFF3, 16'h1234, 2'b11);
    issue(0, 19'h7FFF3, 16'h0000, 2'b11);
    // R4: lower-lane write, upper-lane write, then partial reads
    issue(1, 19'h00003, 16'hFFAB, 2'b01);
    issue(1, 19'h00005, 16'hCDFF, 2'b10);
    issue(0, 19'h00003, 16'h0000, 2'b11);
    issue(0, 19'h00005, 16'h0000, 2'b01);
    issue(0, 19'h00005, 16'h0000, 2'b10);
    // R9: mask-zero write must not alter memory; mask-zero read returns zero
    issue(1, 19'h00003, 16'h0000, 2'b00);
    issue(0, 19'h00003, 16'h0000, 2'b00);
    issue(0, 19'h00003, 16'h0000, 2'b11);
    settle();
    check("R9", "memory untouched by mask-zero write", 32'(arr[3]), 32'(shadow[3]));

    // R2: hold a request valid across busy cycles
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h00007; req_mask = 2'b11;
    repeat (12) @(negedge clk);
    req_valid = 1'b0;
    settle();

    // back-to-back mask-zero requests held valid (R2 R8)
    req_valid = 1'b1; req_mask = 2'b00; req_write = 1'b1;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    settle();

    // mixed pattern
    lf = 32'hACE1_1234;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[5], {lf[24:10], lf[3:0]}, lf[31:16], lf[7:6]);
    end
    settle();
    for (int i = 0; i < 16; i++)
      check("R3 R4", "memory image", 32'(arr[i]), 32'(shadow[i]));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule